// File: doc/BRIEF.md
# Card Command Path Engine

This block is the command-line half of a memory-card host controller. A register write supplies a 6-bit command index, a 32-bit argument and two response controls. When the write also carries the start bit, the engine builds a 48-bit command frame protected by a CRC7. It shifts the frame out one bit per clock on the host-driven command line, and then either finishes or listens on the card-driven line for a short or long reply.

Each command ends in exactly one terminal outcome, which is recorded in a 4-bit sticky flag register:

| Bit | Meaning |
|-----|---------|
| 0 | Command sent |
| 1 | Response received and good |
| 2 | No reply within the listening window |
| 3 | Reply CRC mismatch |

Software clears any flag by writing a one to the matching bit of a separate clear strobe. The received reply is presented as four 32-bit words. Word 0 holds the most significant bits.

Top module: `card_cmd_engine`

## Requirements
- R1: After reset: flags are 0, busy is 0, line_oe is 0, line_o is 1 and all four response words are 0. Whenever line_oe is 0, line_o is 1.
- R2: A write with cmd_start=1 while idle sends 48 bits MSB first on line_o, with line_oe=1 for exactly those 48 cycles:
  - a 0 bit, then a 1 bit;
  - the 6-bit index, then the 32-bit argument;
  - a CRC7 (polynomial x^7+x^3+1, initial value 0) over the preceding 40 bits;
  - a final 1 bit.
- R3: With cmd_want_resp=0, flag bit 0 is set at the end of the last frame bit, and busy falls at that same edge.
- R4: With cmd_want_resp=1 and cmd_long=0, the reply is a 0 start bit followed by 47 bits: the transmission bit, 6 index bits, 32 status bits, CRC7 and an end bit. resp_w0 receives the 32 status bits, resp_w1..resp_w3 become 0, and flag bit 1 is set when the CRC7 over the first 40 reply bits matches.
- R5: With cmd_long=1, the reply is a 0 start bit followed by 135 bits. The last 128 of those bits land in resp_w0..resp_w3, word 0 first. The CRC7 covers the 120 bits held in resp_w0..resp_w3[31:8] and is compared against resp_w3[7:1].
- R6: On a CRC mismatch in either reply format, flag bit 3 is set instead of bit 1. The response words are still loaded.
- R7: The start bit is accepted in any of the 64 cycles after the command end bit. If line_i stays 1 for all 64 samples, flag bit 2 is set.
- R8: A command write with cmd_start=0, or any write while busy, is ignored: no frame, no flag change, and the running frame is unaltered.
- R9: A clr_wr pulse clears exactly the flag bits whose clr_bits are 1 and leaves the others unchanged.
- R10: Every command raises exactly one flag bit, and busy falls on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one command-line bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_start | input | 1 | Start bit of the command write |
| cmd_want_resp | input | 1 | Expect a reply |
| cmd_long | input | 1 | Reply is the 136-bit format |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| clr_wr | input | 1 | Flag clear strobe |
| clr_bits | input | 4 | Ones select flags to clear |
| line_i | input | 1 | Command line from the card |
| line_o | output | 1 | Command line to the card |
| line_oe | output | 1 | Host drives the command line |
| busy | output | 1 | A command is in progress |
| flags | output | 4 | Sticky flags (see the table above) |
| resp_w0 | output | 32 | Reply word 0, most significant |
| resp_w1 | output | 32 | Reply word 1 |
| resp_w2 | output | 32 | Reply word 2 |
| resp_w3 | output | 32 | Reply word 3, least significant |

## Verification
The assertions assume the card never starts a reply while the host is still driving the frame. They also assume reset is held for at least one clock before any write. The flag-clear property further assumes no clear strobe is issued on the edge where a command finishes. The stimulus keeps to these assumptions: the card model waits for line_oe to fall before it drives line_i, and clears are issued only after busy has been observed low for two cycles.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int IDX_W        = 6;
  localparam int ARG_W        = 32;
  localparam int CRC_W        = 7;
  localparam int NFLAG        = 4;
  localparam int FRAME_BITS   = 2 + IDX_W + ARG_W + CRC_W + 1;
  localparam int HDR_BITS     = 2 + IDX_W + ARG_W;
  localparam int RESP_W       = 128;
  localparam int SHORT_BITS   = FRAME_BITS - 1;   // bits after the start bit
  localparam int LONG_BITS    = 135;              // bits after the start bit
  localparam int SHORT_CRC_N  = HDR_BITS - 1;     // covered bits after start
  localparam int LONG_SKIP    = 7;                // tx bit + 6 reserved
  localparam int LONG_CRC_N   = 120;
  localparam int STAT_LSB     = CRC_W + 1;

  localparam int FLG_SENT = 0;
  localparam int FLG_REND = 1;
  localparam int FLG_TMO  = 2;
  localparam int FLG_CRC  = 3;

  function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [CRC_W-1:0] crc7_hdr(input logic [HDR_BITS-1:0] v);
    logic [CRC_W-1:0] c;
    c = '0;
    for (int i = HDR_BITS - 1; i >= 0; i--) c = crc7_step(c, v[i]);
    return c;
  endfunction
endpackage

// File: rtl/ccp_tx.sv
module ccp_tx #(
  parameter int FB = 48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [FB-1:0] frame_in,
  output logic          line_o,
  output logic          line_oe,
  output logic          last
);
  localparam int CW = $clog2(FB);

  logic [FB-1:0] shreg;
  logic [CW-1:0] cnt;
  logic          active;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '1;
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      shreg  <= frame_in;
      cnt    <= CW'(FB - 1);
      active <= 1'b1;
    end else if (active) begin
      shreg <= {shreg[FB-2:0], 1'b1};
      cnt   <= cnt - 1'b1;
      if (cnt == '0) active <= 1'b0;
    end
  end

  assign line_o  = shreg[FB-1];
  assign line_oe = active;
  assign last    = active && (cnt == '0);
endmodule

// File: rtl/ccp_rx.sv
module ccp_rx
  import ccp_pkg::*;
#(
  parameter int TMO_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              long_sel,
  input  logic              line_i,
  output logic              ok,
  output logic              bad,
  output logic              tmo,
  output logic [RESP_W-1:0] resp_q
);
  localparam int TW = $clog2(TMO_CYCLES);
  localparam int BW = $clog2(LONG_BITS + 1);

  typedef enum logic [1:0] {RX_OFF, RX_HUNT, RX_SHIFT} rx_ph_t;

  rx_ph_t            ph;
  logic [TW-1:0]     hunt_cnt;
  logic [BW-1:0]     pos;
  logic [RESP_W-2:0] sreg;
  logic [CRC_W-1:0]  crc;
  logic              long_q;
  logic [RESP_W-1:0] shifted;
  logic              crc_en;
  logic              last;
  logic              match;

  assign shifted = {sreg, line_i};
  assign crc_en  = long_q ? (pos >= BW'(LONG_SKIP) && pos < BW'(LONG_SKIP + LONG_CRC_N))
                          : (pos < BW'(SHORT_CRC_N));
  assign last    = (ph == RX_SHIFT) &&
                   (pos == (long_q ? BW'(LONG_BITS - 1) : BW'(SHORT_BITS - 1)));
  assign match   = (crc == shifted[CRC_W:1]);
  assign ok      = last && match;
  assign bad     = last && !match;
  assign tmo     = (ph == RX_HUNT) && line_i && (hunt_cnt == TW'(TMO_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= RX_OFF;
      hunt_cnt <= '0;
      pos      <= '0;
      sreg     <= '0;
      crc      <= '0;
      long_q   <= 1'b0;
      resp_q   <= '0;
    end else begin
      unique case (ph)
        RX_OFF: if (arm) begin
          ph       <= RX_HUNT;
          hunt_cnt <= '0;
          long_q   <= long_sel;
        end
        RX_HUNT: begin
          if (!line_i) begin
            ph  <= RX_SHIFT;
            pos <= '0;
            crc <= '0;
          end else if (tmo) begin
            ph <= RX_OFF;
          end else begin
            hunt_cnt <= hunt_cnt + 1'b1;
          end
        end
        RX_SHIFT: begin
          sreg <= shifted[RESP_W-2:0];
          pos  <= pos + 1'b1;
          if (crc_en) crc <= crc7_step(crc, line_i);
          if (last) begin
            ph <= RX_OFF;
            if (long_q) resp_q <= shifted;
            else resp_q <= {shifted[STAT_LSB+ARG_W-1:STAT_LSB], {(RESP_W-ARG_W){1'b0}}};
          end
        end
        default: ph <= RX_OFF;
      endcase
    end
  end
endmodule

// File: rtl/ccp_flags.sv
module ccp_flags #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set_bits,
  input  logic          clr_wr,
  input  logic [NF-1:0] clr_bits,
  output logic [NF-1:0] flags_q
);
  logic [NF-1:0] clr_mask;
  assign clr_mask = clr_wr ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (flags_q & ~clr_mask) | set_bits;
  end
endmodule

// File: rtl/card_cmd_engine.sv
module card_cmd_engine
  import ccp_pkg::*;
#(
  parameter int TMO_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic             cmd_start,
  input  logic             cmd_want_resp,
  input  logic             cmd_long,
  input  logic [IDX_W-1:0] cmd_index,
  input  logic [ARG_W-1:0] cmd_arg,
  input  logic             clr_wr,
  input  logic [NFLAG-1:0] clr_bits,
  input  logic             line_i,
  output logic             line_o,
  output logic             line_oe,
  output logic             busy,
  output logic [NFLAG-1:0] flags,
  output logic [31:0]      resp_w0,
  output logic [31:0]      resp_w1,
  output logic [31:0]      resp_w2,
  output logic [31:0]      resp_w3
);
  typedef enum logic [1:0] {S_IDLE, S_SEND, S_LISTEN} eng_st_t;

  eng_st_t              st;
  logic                 want_q;
  logic                 long_q;
  logic                 accept;
  logic [HDR_BITS-1:0]  hdr;
  logic [FRAME_BITS-1:0] frame;
  logic                 tx_last;
  logic                 rx_ok, rx_bad, rx_tmo;
  logic                 arm;
  logic [NFLAG-1:0]     set_bits;
  logic [RESP_W-1:0]    resp_q;

  assign accept = cmd_wr && cmd_start && (st == S_IDLE);
  assign hdr    = {1'b0, 1'b1, cmd_index, cmd_arg};
  assign frame  = {hdr, crc7_hdr(hdr), 1'b1};
  assign arm    = (st == S_SEND) && tx_last && want_q;

  always_comb begin
    set_bits           = '0;
    set_bits[FLG_SENT] = (st == S_SEND) && tx_last && !want_q;
    set_bits[FLG_REND] = (st == S_LISTEN) && rx_ok;
    set_bits[FLG_CRC]  = (st == S_LISTEN) && rx_bad;
    set_bits[FLG_TMO]  = (st == S_LISTEN) && rx_tmo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      want_q <= 1'b0;
      long_q <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (accept) begin
          st     <= S_SEND;
          want_q <= cmd_want_resp;
          long_q <= cmd_long;
        end
        S_SEND:   if (tx_last) st <= want_q ? S_LISTEN : S_IDLE;
        S_LISTEN: if (rx_ok || rx_bad || rx_tmo) st <= S_IDLE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  ccp_tx #(.FB(FRAME_BITS)) tx_i (
    .clk(clk), .rst(rst), .load(accept), .frame_in(frame),
    .line_o(line_o), .line_oe(line_oe), .last(tx_last)
  );

  ccp_rx #(.TMO_CYCLES(TMO_CYCLES)) rx_i (
    .clk(clk), .rst(rst), .arm(arm), .long_sel(long_q), .line_i(line_i),
    .ok(rx_ok), .bad(rx_bad), .tmo(rx_tmo), .resp_q(resp_q)
  );

  ccp_flags #(.NF(NFLAG)) flg_i (
    .clk(clk), .rst(rst), .set_bits(set_bits), .clr_wr(clr_wr),
    .clr_bits(clr_bits), .flags_q(flags)
  );

  assign busy    = (st != S_IDLE);
  assign resp_w0 = resp_q[127:96];
  assign resp_w1 = resp_q[95:64];
  assign resp_w2 = resp_q[63:32];
  assign resp_w3 = resp_q[31:0];
endmodule

// File: rtl/ccp_chk.sv
module ccp_chk (
  input logic       clk,
  input logic       rst,
  input logic       clr_wr,
  input logic [3:0] clr_bits,
  input logic       line_o,
  input logic       line_oe,
  input logic       busy,
  input logic [3:0] flags
);
  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
    !line_oe |-> line_o);

  // R2
  drive_in_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    line_oe |-> busy);

  // R10
  single_raise_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(flags & ~$past(flags)) <= 1);

  // R10
  end_has_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (flags != 4'b0000));

  // R9
  clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !busy) |=> ((flags & $past(clr_bits)) == 4'b0000));
endmodule

bind card_cmd_engine ccp_chk chk_i (
  .clk(clk), .rst(rst), .clr_wr(clr_wr), .clr_bits(clr_bits),
  .line_o(line_o), .line_oe(line_oe), .busy(busy), .flags(flags)
);

// File: tb/card_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module card_cmd_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr = 1'b0, cmd_start = 1'b0, cmd_want_resp = 1'b0, cmd_long = 1'b0;
  logic [5:0]  cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic        clr_wr = 1'b0;
  logic [3:0]  clr_bits = '0;
  logic        line_i = 1'b1;
  logic        line_o, line_oe, busy;
  logic [3:0]  flags;
  logic [31:0] resp_w0, resp_w1, resp_w2, resp_w3;

  always #2 clk = ~clk;

  card_cmd_engine dut_i (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_start(cmd_start),
    .cmd_want_resp(cmd_want_resp), .cmd_long(cmd_long), .cmd_index(cmd_index),
    .cmd_arg(cmd_arg), .clr_wr(clr_wr), .clr_bits(clr_bits), .line_i(line_i),
    .line_o(line_o), .line_oe(line_oe), .busy(busy), .flags(flags),
    .resp_w0(resp_w0), .resp_w1(resp_w1), .resp_w2(resp_w2), .resp_w3(resp_w3)
  );

  int n_chk = 0;
  int n_bad = 0;

  typedef struct packed {
    logic [3:0]   flg;
    logic         chk_resp;
    logic [127:0] words;
  } exp_t;

  exp_t        exp_q[$];
  string       tag_q[$];
  logic [47:0] frame_q[$];

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [6:0] tb_crc(input logic [119:0] v, input int n);
    logic [6:0] c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb = v[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'b0001001;
    end
    return c;
  endfunction

  // Monitor: frame capture and completion scoreboard
  logic [47:0] cap = '0;
  int          ncap = 0;
  logic        prev_busy = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (line_oe) begin
        cap = {cap[46:0], line_o};
        ncap++;
      end else if (ncap != 0) begin
        logic [47:0] ef;
        ef = (frame_q.size() != 0) ? frame_q.pop_front() : 48'h0;
        check("R2 frame bits", {80'h0, cap}, {80'h0, ef});
        check("R2 frame length", 128'(ncap), 128'd48);
        ncap = 0;
      end
      if (prev_busy && !busy) begin
        exp_t  e;
        string t;
        if (exp_q.size() == 0) begin
          check("R10 unexpected completion", 128'd1, 128'd0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({t, " flags"}, {124'h0, flags}, {124'h0, e.flg});
          if (e.chk_resp)
            check({t, " words"}, {resp_w0, resp_w1, resp_w2, resp_w3}, e.words);
        end
      end
      prev_busy = busy;
    end
  end

  task automatic clear_flags(input logic [3:0] m);
    @(negedge clk);
    clr_wr = 1'b1;
    clr_bits = m;
    @(negedge clk);
    clr_wr = 1'b0;
    clr_bits = '0;
  endtask

  // Driver: issues a command, queues expectations, plays the card
  task automatic do_cmd(input logic [5:0] idx, input logic [31:0] arg, input bit want,
                        input bit lng, input bit silent, input int dly,
                        input logic [127:0] pay, input bit corrupt, input bit poke,
                        input string tag);
    logic [39:0]  hdr;
    logic [135:0] rv;
    int           nb;
    exp_t         e;
    hdr = {2'b01, idx, arg};
    frame_q.push_back({hdr, tb_crc({80'h0, hdr}, 40), 1'b1});
    e = '0;
    nb = 0;
    rv = '0;
    if (!want) begin
      e.flg = 4'b0001;
    end else if (silent) begin
      e.flg = 4'b0100;
    end else if (!lng) begin
      logic [39:0] rh;
      logic [6:0]  rc;
      rh = {2'b00, idx, pay[31:0]};
      rc = tb_crc({80'h0, rh}, 40);
      if (corrupt) rc[0] = ~rc[0];
      rv = {88'h0, rh, rc, 1'b1};
      nb = 48;
      e.flg = corrupt ? 4'b1000 : 4'b0010;
      e.chk_resp = 1'b1;
      e.words = {pay[31:0], 96'h0};
    end else begin
      logic [127:0] ct;
      ct = {pay[127:8], tb_crc(pay[127:8], 120), 1'b1};
      if (corrupt) ct[1] = ~ct[1];
      rv = {8'b00111111, ct};
      nb = 136;
      e.flg = corrupt ? 4'b1000 : 4'b0010;
      e.chk_resp = 1'b1;
      e.words = ct;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_start = 1'b1; cmd_want_resp = want; cmd_long = lng;
    cmd_index = idx; cmd_arg = arg;
    @(negedge clk);
    cmd_wr = 1'b0;
    if (poke) begin
      repeat (10) @(negedge clk);
      cmd_wr = 1'b1; cmd_index = ~idx; cmd_arg = ~arg; cmd_want_resp = 1'b0;
      @(negedge clk);
      cmd_wr = 1'b0;
    end
    while (line_oe) @(negedge clk);
    if (want && !silent) begin
      repeat (dly) @(negedge clk);
      for (int i = nb - 1; i >= 0; i--) begin
        line_i = rv[i];
        @(negedge clk);
      end
      line_i = 1'b1;
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 flags", {124'h0, flags}, 128'h0);
    check("R1 busy/oe/line", {125'h0, busy, line_oe, line_o}, 128'h1);
    check("R1 words", {resp_w0, resp_w1, resp_w2, resp_w3}, 128'h0);

    // R3 no reply
    do_cmd(6'd0, 32'h0, 0, 0, 0, 0, '0, 0, 0, "R3 sent");
    // R9 partial clear keeps the other bits
    clear_flags(4'b1110);
    check("R9 keep sent", {124'h0, flags}, 128'h1);
    clear_flags(4'b0001);
    check("R9 cleared", {124'h0, flags}, 128'h0);

    // R4 short reply
    do_cmd(6'd17, 32'hDEADBEEF, 1, 0, 0, 5, 128'h12345678, 0, 0, "R4 short");
    clear_flags(4'hF);
    // R7 start bit on the last allowed sample
    do_cmd(6'd63, 32'h0000_FFFF, 1, 0, 0, 63, 128'hA5A5_0F0F, 0, 0, "R7 late start");
    clear_flags(4'hF);
    // R7 silent card
    do_cmd(6'd8, 32'h1AA, 1, 0, 1, 0, '0, 0, 0, "R7 timeout");
    clear_flags(4'hF);
    // R5 long reply
    do_cmd(6'd2, 32'h0, 1, 1, 0, 3,
           128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 0, 0, "R5 long");
    clear_flags(4'hF);
    // R6 corrupted short and long
    do_cmd(6'd13, 32'h0001_0000, 1, 0, 0, 1, 128'h0000_0900, 1, 0, "R6 short crc");
    clear_flags(4'hF);
    do_cmd(6'd9, 32'h0002_0000, 1, 1, 0, 0,
           128'hFFFF_0000_AAAA_5555_1234_0000_CAFE_F00D, 1, 0, "R6 long crc");
    clear_flags(4'hF);

    // R8 write with start bit low
    @(negedge clk);
    cmd_wr = 1'b1; cmd_start = 1'b0; cmd_index = 6'd5;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_start = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 no start", {124'h0, flags, 1'b0, busy, line_oe}, 128'h0);

    // R8 write while busy leaves frame and result intact
    do_cmd(6'd24, 32'h5555_AAAA, 0, 0, 0, 0, '0, 0, 1, "R8 busy write");
    check("R8 no second cmd", {126'h0, busy, line_oe}, 128'h0);
    clear_flags(4'hF);
    check("R9 all clear", {124'h0, flags}, 128'h0);

    repeat (4) @(negedge clk);
    check("R10 queue drained", 128'(exp_q.size() + frame_q.size()), 128'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule